// File: doc/BRIEF.md
# One-Bit Decision Processor Core

This block is a single-bit processor for ladder-logic style control. On every rising clock edge it takes a 4-bit opcode from `instr_i` and samples the one-bit data bus `din_i`. It holds a one-bit result register that logic operations update. It can copy that register, true or inverted, onto a registered data output `dout_o` and mark the copy with a one-cycle write strobe. Two enable latches gate the data paths. The input enable forces the sampled data to zero while it is clear. The output enable blocks every store while it is clear.

The core has no program counter. The address of the next instruction comes from an external counter, which can be any width. The jump and return instructions change no working state inside the core. They only raise a one-cycle flag that the external sequencing logic acts on. The two no-op codes also raise flags of their own, so the code around the core can use them as markers.

Control is a two-state machine. `ST_RUN` executes the instruction on the port. `ST_SKIP` spends exactly one cycle ignoring the instruction on the port. The core goes from `ST_RUN` to `ST_SKIP` after a return instruction, or after a skip-if-zero instruction while the result register is 0. In every other case it stays in `ST_RUN`. From `ST_SKIP` it always goes back to `ST_RUN` after one cycle.

Top module: `bitdec_core`

## Requirements
- R1: After reset the result register, input enable, output enable, `dout_o`, `wr_o` and all four flag outputs are 0, and the machine is in `ST_RUN`.
- R2: Opcode 1 loads the gated data (`din_i` AND input enable) into the result register. Opcode 2 loads the complement of the gated data.
- R3: With gated data g and result r, the next result is: opcode 3 gives r AND g, opcode 4 gives r AND NOT g, opcode 5 gives r OR g, opcode 6 gives r OR NOT g, and opcode 7 gives NOT (r XOR g).
- R4: While the output enable is 1, opcode 8 drives r and opcode 9 drives NOT r onto `dout_o`. The new value appears one cycle after the instruction is sampled, together with a one-cycle `wr_o` pulse. `dout_o` changes at no other time.
- R5: While the output enable is 0, opcodes 8 and 9 leave `dout_o` unchanged and do not assert `wr_o`.
- R6: Opcode A loads the input enable and opcode B loads the output enable. Both take the raw `din_i`, whatever the input enable holds.
- R7: Opcode C pulses `jmp_o` for one cycle and leaves the result register and both enables unchanged.
- R8: Opcode E causes the next instruction to be skipped when the result register is 0. When the result register is 1, the next instruction executes.
- R9: Opcode D pulses `rtn_o` for one cycle and always causes the next instruction to be skipped.
- R10: A skipped instruction takes one cycle. It changes neither the result register, the enables nor `dout_o`, and it asserts no flag and no strobe. A skipped opcode D or E does not cause a further skip.
- R11: Opcode 0 pulses `nop0_o` and opcode F pulses `nopf_o`, each for one cycle, with no other effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_i | input | 4 | Opcode for this cycle |
| din_i | input | 1 | One-bit data bus input |
| dout_o | output | 1 | Registered data output |
| wr_o | output | 1 | One-cycle write strobe for a store |
| jmp_o | output | 1 | One-cycle jump flag |
| rtn_o | output | 1 | One-cycle return flag |
| nop0_o | output | 1 | One-cycle flag for opcode 0 |
| nopf_o | output | 1 | One-cycle flag for opcode F |

## Verification
The hardest situation to reach from the ports is a skipped instruction that would otherwise have had a visible effect. Examples are a store while the output enable is set, or a skip or return that could start a chain of skips. The result register is not a port, so its value can only be seen through a later store. The bench therefore builds every combination of result, enables and data with short preamble sequences. It puts each of the 16 opcodes behind both kinds of skip-causing instruction. It then enables the output and stores, so that any stray change to the register shows on `dout_o`.

// File: rtl/bitdec_pkg.sv
package bitdec_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_NOP0 = 4'h0,
        OP_LD   = 4'h1,
        OP_LDC  = 4'h2,
        OP_AND  = 4'h3,
        OP_ANDC = 4'h4,
        OP_OR   = 4'h5,
        OP_ORC  = 4'h6,
        OP_XNOR = 4'h7,
        OP_STO  = 4'h8,
        OP_STOC = 4'h9,
        OP_IEN  = 4'hA,
        OP_OEN  = 4'hB,
        OP_JMP  = 4'hC,
        OP_RTN  = 4'hD,
        OP_SKZ  = 4'hE,
        OP_NOPF = 4'hF
    } op_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_SKIP = 1'b1
    } st_e;

    typedef struct packed {
        logic nop0;
        logic nopf;
        logic rr_we;
        logic sto;
        logic sto_inv;
        logic ien_we;
        logic oen_we;
        logic jmp;
        logic rtn;
        logic skz;
    } ctl_t;

endpackage

// File: rtl/bitdec_decode.sv
module bitdec_decode
    import bitdec_pkg::*;
(
    input  op_e  op,
    output ctl_t ctl
);

    always_comb begin
        ctl = '0;
        unique case (op)
            OP_NOP0: ctl.nop0   = 1'b1;
            OP_LD, OP_LDC, OP_AND, OP_ANDC,
            OP_OR, OP_ORC, OP_XNOR:
                     ctl.rr_we  = 1'b1;
            OP_STO:  ctl.sto    = 1'b1;
            OP_STOC: begin
                     ctl.sto     = 1'b1;
                     ctl.sto_inv = 1'b1;
            end
            OP_IEN:  ctl.ien_we = 1'b1;
            OP_OEN:  ctl.oen_we = 1'b1;
            OP_JMP:  ctl.jmp    = 1'b1;
            OP_RTN:  ctl.rtn    = 1'b1;
            OP_SKZ:  ctl.skz    = 1'b1;
            OP_NOPF: ctl.nopf   = 1'b1;
            default: ctl = '0;
        endcase
    end

endmodule

// File: rtl/bitdec_logic.sv
module bitdec_logic
    import bitdec_pkg::*;
(
    input  op_e  op,
    input  logic rr,
    input  logic gd,
    output logic rr_nxt
);

    always_comb begin
        unique case (op)
            OP_LD:   rr_nxt = gd;
            OP_LDC:  rr_nxt = ~gd;
            OP_AND:  rr_nxt = rr & gd;
            OP_ANDC: rr_nxt = rr & ~gd;
            OP_OR:   rr_nxt = rr | gd;
            OP_ORC:  rr_nxt = rr | ~gd;
            OP_XNOR: rr_nxt = ~(rr ^ gd);
            default: rr_nxt = rr;
        endcase
    end

endmodule

// File: rtl/bitdec_seq.sv
module bitdec_seq
    import bitdec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic skip_req,
    output st_e  st,
    output logic active
);

    st_e st_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_RUN;
        else        st <= st_nxt;
    end

    always_comb begin
        unique case (st)
            ST_RUN:  st_nxt = skip_req ? ST_SKIP : ST_RUN;
            ST_SKIP: st_nxt = ST_RUN;
            default: st_nxt = ST_RUN;
        endcase
    end

    assign active = (st == ST_RUN);

    assert_skip_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SKIP) |=> (st == ST_RUN));

endmodule

// File: rtl/bitdec_core.sv
module bitdec_core
    import bitdec_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] instr_i,
    input  logic            din_i,
    output logic            dout_o,
    output logic            wr_o,
    output logic            jmp_o,
    output logic            rtn_o,
    output logic            nop0_o,
    output logic            nopf_o
);

    op_e  op;
    ctl_t ctl;
    st_e  st;
    logic active;
    logic rr_q, ien_q, oen_q;
    logic gd, rr_nxt, skip_req;

    assign op = op_e'(instr_i);
    assign gd = din_i & ien_q;
    assign skip_req = ctl.rtn | (ctl.skz & ~rr_q);

    bitdec_decode i_dec (.op(op), .ctl(ctl));

    bitdec_logic i_lu (.op(op), .rr(rr_q), .gd(gd), .rr_nxt(rr_nxt));

    bitdec_seq i_seq (
        .clk(clk), .rst_n(rst_n), .skip_req(skip_req),
        .st(st), .active(active)
    );

    // working state: result register and the two enable latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rr_q  <= 1'b0;
            ien_q <= 1'b0;
            oen_q <= 1'b0;
        end else if (active) begin
            if (ctl.rr_we)  rr_q  <= rr_nxt;
            if (ctl.ien_we) ien_q <= din_i;
            if (ctl.oen_we) oen_q <= din_i;
        end
    end

    // registered outputs: data, strobe and event flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_o <= 1'b0;
            wr_o   <= 1'b0;
            jmp_o  <= 1'b0;
            rtn_o  <= 1'b0;
            nop0_o <= 1'b0;
            nopf_o <= 1'b0;
        end else begin
            wr_o   <= active & ctl.sto & oen_q;
            jmp_o  <= active & ctl.jmp;
            rtn_o  <= active & ctl.rtn;
            nop0_o <= active & ctl.nop0;
            nopf_o <= active & ctl.nopf;
            if (active && ctl.sto && oen_q)
                dout_o <= rr_q ^ ctl.sto_inv;
        end
    end

    assert_wr_needs_oen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o |-> $past(oen_q));

    assert_dout_only_on_wr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_o |-> $stable(dout_o));

    assert_events_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_o, jmp_o, rtn_o, nop0_o, nopf_o}));

    assert_rtn_skips_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rtn_o |-> (st == ST_SKIP));

    assert_skip_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SKIP) |=> (!wr_o && !jmp_o && !rtn_o && !nop0_o && !nopf_o
                             && $stable(rr_q) && $stable(ien_q) && $stable(oen_q)));

    assert_jmp_keeps_rr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        jmp_o |-> $stable(rr_q));

endmodule

// File: tb/test_bitdec_core.sv
`timescale 1ns/1ps
module test_bitdec_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] instr = 4'h0;
    logic       din = 1'b0;
    logic       dout, wr, jmp, rtn, nop0, nopf;

    int errors = 0;
    int checks = 0;

    // reference state
    logic m_rr = 1'b0, m_ien = 1'b0, m_oen = 1'b0, m_dout = 1'b0, m_skip = 1'b0;

    always #10 clk = ~clk;

    bitdec_core i_bitdec_core (
        .clk(clk), .rst_n(rst_n), .instr_i(instr), .din_i(din),
        .dout_o(dout), .wr_o(wr), .jmp_o(jmp), .rtn_o(rtn),
        .nop0_o(nop0), .nopf_o(nopf)
    );

    function automatic string tag_of(input logic [3:0] op, input logic skipped);
        if (skipped) return "R10";
        case (op)
            4'h1, 4'h2:       return "R2";
            4'h3, 4'h4, 4'h5,
            4'h6, 4'h7:       return "R3";
            4'h8, 4'h9:       return m_oen ? "R4" : "R5";
            4'hA, 4'hB:       return "R6";
            4'hC:             return "R7";
            4'hD:             return "R9";
            4'hE:             return "R8";
            default:          return "R11";
        endcase
    endfunction

    task automatic step(input logic [3:0] op, input logic d, input string force_tag);
        logic e_wr = 1'b0, e_j = 1'b0, e_r = 1'b0, e_n0 = 1'b0, e_nf = 1'b0;
        logic g;
        string tag;
        logic [5:0] act, exp;
        tag = (force_tag != "") ? force_tag : tag_of(op, m_skip);
        @(negedge clk);
        instr = op;
        din   = d;
        @(posedge clk);
        #2;
        if (m_skip) begin
            m_skip = 1'b0;
        end else begin
            g = d & m_ien;
            case (op)
                4'h0: e_n0 = 1'b1;
                4'h1: m_rr = g;
                4'h2: m_rr = !g;
                4'h3: m_rr = m_rr & g;
                4'h4: m_rr = m_rr & !g;
                4'h5: m_rr = m_rr | g;
                4'h6: m_rr = m_rr | !g;
                4'h7: m_rr = (m_rr == g);
                4'h8: if (m_oen) begin m_dout = m_rr;  e_wr = 1'b1; end
                4'h9: if (m_oen) begin m_dout = !m_rr; e_wr = 1'b1; end
                4'hA: m_ien = d;
                4'hB: m_oen = d;
                4'hC: e_j = 1'b1;
                4'hD: begin e_r = 1'b1; m_skip = 1'b1; end
                4'hE: if (!m_rr) m_skip = 1'b1;
                default: e_nf = 1'b1;
            endcase
        end
        act = {dout, wr, jmp, rtn, nop0, nopf};
        exp = {m_dout, e_wr, e_j, e_r, e_n0, e_nf};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s op=%h d=%b {dout,wr,jmp,rtn,nop0,nopf} actual=%b expected=%b",
                     tag, op, d, act, exp);
        end
    endtask

    // bring the core to a known rr / ien / oen
    task automatic setup(input logic rr, input logic ien, input logic oen);
        step(4'hA, 1'b1, "");
        step(4'h1, rr,   "");
        step(4'hB, oen,  "");
        step(4'hA, ien,  "");
    endtask

    // expose rr on dout through a store
    task automatic probe();
        step(4'h0, 1'b0, "");
        step(4'hB, 1'b1, "");
        step(4'h8, 1'b0, "");
    endtask

    initial begin : watchdog
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #35;
        checks++;
        if ({dout, wr, jmp, rtn, nop0, nopf} !== 6'b0) begin
            errors++;
            $display("FAIL R1 outputs in reset actual=%b expected=000000",
                     {dout, wr, jmp, rtn, nop0, nopf});
        end
        rst_n = 1'b1;
        // R1: input enable clear after reset, so a load of 1 gives 0
        step(4'h1, 1'b1, "R1");
        step(4'hB, 1'b1, "R1");
        step(4'h8, 1'b0, "R1");

        // exhaustive: every opcode against every rr/ien/oen/din
        for (int op = 0; op < 16; op++) begin
            for (int c = 0; c < 16; c++) begin
                setup(c[0], c[1], c[2]);
                step(op[3:0], c[3], "");
                probe();
            end
        end

        // every opcode behind each skip-causing instruction
        for (int pre = 0; pre < 2; pre++) begin
            for (int op = 0; op < 16; op++) begin
                for (int c = 0; c < 4; c++) begin
                    setup(1'b0, c[0], 1'b1);
                    step(pre ? 4'hD : 4'hE, 1'b0, pre ? "R9" : "R8");
                    step(op[3:0], c[1], "R10");
                    probe();
                end
            end
        end

        // R8: skip not taken when rr is 1
        setup(1'b1, 1'b1, 1'b1);
        step(4'hE, 1'b0, "R8");
        step(4'h9, 1'b0, "R8");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule